// File: doc/BRIEF.md
# Linked Buffer-Descriptor Sequencer for a Serial Flash Port

This block walks a chain of buffer descriptors in system memory and turns each one into a command for a serial shifter. It also moves that descriptor's payload between memory and the shifter's byte streams. Software writes the descriptors, puts the address of the first one on `base_addr`, holds `dma_en` high and pulses `go`.

A descriptor is four 32-bit words at consecutive word addresses:

| Offset | Word |
|---|---|
| +0 | control |
| +4 | status |
| +8 | buffer address |
| +12 | next-descriptor pointer |

The engine does the following for each descriptor:
- reads the control word and checks that hardware owns the descriptor;
- reads the buffer and link words;
- hands the shifter one command;
- streams the payload bytes;
- writes the descriptor back with ownership returned to software and the byte count in the status word.

The engine then follows the link, or stops and signals packet completion. Memory traffic goes through a single word-wide request port that holds each request until it is acknowledged. The payload is packed little-endian: byte k of a buffer sits in word k/4, bits 8*(k mod 4) upward.

Top module: `spi_desc_dma`

## Requirements
- R1: Out of reset the engine is idle with no memory request, command or byte offered. After a `go` pulse with `dma_en` high, it reads the control, buffer-address (+8) and next-pointer (+12) words of the descriptor at `base_addr`. It processes each linked descriptor in chain order.
- R2: If a fetched control word has bit 31 (hardware ownership) clear while `poll_en` is low, the engine pulses `ev_err` and returns to idle. It issues no command and no write-back.
- R3: If a fetched control word has bit 31 clear while `poll_en` is high, the engine re-reads that control word until bit 31 is found set. It then processes the descriptor normally.
- R4: Each descriptor yields exactly one command, whose fields come from the control word:
  - `cmd_len`: bits 8:0, limited to 256;
  - `cmd_rx`: bit 20;
  - `cmd_ddr`: bit 21;
  - `cmd_lsb_first`: bit 25;
  - `cmd_status_poll`: bit 27;
  - `cmd_dev`: bits 29:28;
  - `cmd_cs_release`: bit 30;
  - `cmd_last`: bit 18;
  - `cmd_lanes`: 2 (quad) if bit 23 is set, else 1 (dual) if bit 22 is set, else 0 (single).
- R5: For a transmit descriptor (bit 20 clear), the engine offers exactly `cmd_len` bytes on `tx_data`, read little-endian from the buffer starting at byte 0.
- R6: For a receive descriptor (bit 20 set), the engine packs exactly `cmd_len` bytes from `rx_data` little-endian into the buffer. The unused upper bytes of a final partial word are written as zero.
- R7: After its data, each descriptor is written back: the control word with bit 31 cleared at +0, then the transferred byte count at +4.
- R8: `ev_bd_done` pulses once per written-back descriptor whose control bit 16 is set. It pulses the cycle after the acknowledge of the status write.
- R9: The chain stops after a descriptor with control bit 19 set or with a zero next pointer. `ev_pkt_done` pulses on that stop if its bit 17 is set, and the engine is idle in that same cycle.
- R10: If `dma_en` falls during a descriptor, the engine returns to idle at the next completed byte or memory handshake. It raises no completion event and writes nothing back.
- R11: A `go` pulse while `dma_en` is low, or while the engine is busy, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dma_en | input | 1 | Engine enable; low aborts |
| poll_en | input | 1 | Re-read unowned descriptors instead of failing |
| go | input | 1 | Start pulse |
| base_addr | input | AW | Byte address of first descriptor |
| busy | output | 1 | Engine not idle |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request done; read data valid |
| mem_rdata | input | 32 | Read data |
| cmd_valid | output | 1 | Shifter command offered |
| cmd_ready | input | 1 | Shifter takes command |
| cmd_len | output | LW | Byte count |
| cmd_rx | output | 1 | Receive direction |
| cmd_lanes | output | 2 | 0 single, 1 dual, 2 quad |
| cmd_lsb_first | output | 1 | Bit order |
| cmd_ddr | output | 1 | Double data rate |
| cmd_dev | output | 2 | Device select |
| cmd_cs_release | output | 1 | Release select after this command |
| cmd_last | output | 1 | Last data of packet |
| cmd_status_poll | output | 1 | Status-poll descriptor flag |
| tx_valid | output | 1 | Transmit byte offered |
| tx_ready | input | 1 | Shifter takes transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Engine takes receive byte |
| rx_data | input | 8 | Receive byte |
| ev_bd_done | output | 1 | Descriptor completion pulse |
| ev_pkt_done | output | 1 | Packet completion pulse |
| ev_err | output | 1 | Ownership error pulse |

## Verification
Memory results are checked only after `busy` has fallen. The event pulses appear in the cycle in which `busy` falls, so the bench waits two further falling edges before it reads its event tallies. The data streams, commands and memory acknowledges all use handshakes with random stalls. For that reason the bench logs every accepted command and byte at the rising edge and compares the logs with its own expected values after the run, rather than expecting any result in a fixed cycle. The abort and polling cases use bounded waits of 40 cycles, because an abort takes effect within one handshake.

// File: rtl/spi_desc_dma.sv
module spi_desc_dma #(
  parameter int AW = 32,
  parameter int MAXLEN = 256,
  localparam int LW = $clog2(MAXLEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dma_en,
  input  logic          poll_en,
  input  logic          go,
  input  logic [AW-1:0] base_addr,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [LW-1:0] cmd_len,
  output logic          cmd_rx,
  output logic [1:0]    cmd_lanes,
  output logic          cmd_lsb_first,
  output logic          cmd_ddr,
  output logic [1:0]    cmd_dev,
  output logic          cmd_cs_release,
  output logic          cmd_last,
  output logic          cmd_status_poll,
  output logic          tx_valid,
  input  logic          tx_ready,
  output logic [7:0]    tx_data,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  output logic          ev_bd_done,
  output logic          ev_pkt_done,
  output logic          ev_err
);

  localparam int OWN_BIT = 31;

  typedef enum logic [3:0] {
    S_IDLE, S_RCTL, S_RADR, S_RNXT, S_CMD,
    S_TLD, S_TOUT, S_RIN, S_RST, S_WCTL, S_WSTA
  } state_t;

  state_t        st;
  logic [AW-1:0] ptr, bufa, nxt;
  logic [31:0]   ctl, wb;
  logic [LW-1:0] len, cnt, cnt_n, di, len_in;
  logic [1:0]    lane;
  logic [AW-1:0] daddr;
  logic          last_byte, stop;

  assign cnt_n     = cnt + LW'(1);
  assign last_byte = (cnt_n == len);
  assign lane      = cnt[1:0];
  assign di        = (st == S_RST) ? cnt - LW'(1) : cnt;
  assign daddr     = bufa + (AW'(di) & ~AW'(3));
  assign len_in    = (mem_rdata[8:0] > 9'(MAXLEN)) ? LW'(MAXLEN) : LW'(mem_rdata[8:0]);
  assign stop      = ctl[19] || (nxt == '0);

  assign busy     = (st != S_IDLE);
  assign mem_req  = st inside {S_RCTL, S_RADR, S_RNXT, S_TLD, S_RST, S_WCTL, S_WSTA};
  assign mem_we   = st inside {S_RST, S_WCTL, S_WSTA};

  always_comb begin
    case (st)
      S_RADR:        mem_addr = ptr + AW'(8);
      S_RNXT:        mem_addr = ptr + AW'(12);
      S_WSTA:        mem_addr = ptr + AW'(4);
      S_TLD, S_RST:  mem_addr = daddr;
      default:       mem_addr = ptr;
    endcase
    case (st)
      S_WCTL:  mem_wdata = ctl & ~(32'd1 << OWN_BIT);
      S_WSTA:  mem_wdata = 32'(cnt);
      S_RST:   mem_wdata = wb;
      default: mem_wdata = '0;
    endcase
  end

  assign cmd_valid       = (st == S_CMD);
  assign cmd_len         = len;
  assign cmd_rx          = ctl[20];
  assign cmd_ddr         = ctl[21];
  assign cmd_lanes       = ctl[23] ? 2'd2 : (ctl[22] ? 2'd1 : 2'd0);
  assign cmd_lsb_first   = ctl[25];
  assign cmd_status_poll = ctl[27];
  assign cmd_dev         = ctl[29:28];
  assign cmd_cs_release  = ctl[30];
  assign cmd_last        = ctl[18];

  assign tx_valid = (st == S_TOUT);
  assign tx_data  = wb[{lane, 3'b000} +: 8];
  assign rx_ready = (st == S_RIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= '0; bufa <= '0; nxt <= '0;
      ctl <= '0; wb <= '0; len <= '0; cnt <= '0;
      ev_bd_done <= 1'b0; ev_pkt_done <= 1'b0; ev_err <= 1'b0;
    end else begin
      ev_bd_done <= 1'b0;
      ev_pkt_done <= 1'b0;
      ev_err <= 1'b0;
      case (st)
        S_IDLE: if (go && dma_en) begin
          ptr <= base_addr;
          st  <= S_RCTL;
        end
        S_RCTL: if (mem_ack) begin
          if (!dma_en) st <= S_IDLE;
          else if (!mem_rdata[OWN_BIT]) begin
            if (!poll_en) begin
              ev_err <= 1'b1;
              st <= S_IDLE;
            end
          end else begin
            ctl <= mem_rdata;
            len <= len_in;
            st  <= S_RADR;
          end
        end
        S_RADR: if (mem_ack) begin
          bufa <= mem_rdata[AW-1:0];
          st <= dma_en ? S_RNXT : S_IDLE;
        end
        S_RNXT: if (mem_ack) begin
          nxt <= mem_rdata[AW-1:0];
          st <= dma_en ? S_CMD : S_IDLE;
        end
        S_CMD: if (cmd_ready) begin
          cnt <= '0;
          if (!dma_en)        st <= S_IDLE;
          else if (len == '0) st <= S_WCTL;
          else if (ctl[20])   st <= S_RIN;
          else                st <= S_TLD;
        end
        S_TLD: if (mem_ack) begin
          wb <= mem_rdata;
          st <= dma_en ? S_TOUT : S_IDLE;
        end
        S_TOUT: if (tx_ready) begin
          cnt <= cnt_n;
          if (!dma_en)              st <= S_IDLE;
          else if (last_byte)       st <= S_WCTL;
          else if (cnt_n[1:0] == 0) st <= S_TLD;
        end
        S_RIN: begin
          if (rx_valid) begin
            wb  <= (lane == 2'd0) ? {24'd0, rx_data}
                                  : wb | (32'(rx_data) << {lane, 3'b000});
            cnt <= cnt_n;
            if (!dma_en)                                st <= S_IDLE;
            else if (last_byte || cnt_n[1:0] == 2'd0)   st <= S_RST;
          end else if (!dma_en) begin
            st <= S_IDLE;
          end
        end
        S_RST: if (mem_ack) begin
          if (!dma_en)         st <= S_IDLE;
          else if (cnt == len) st <= S_WCTL;
          else                 st <= S_RIN;
        end
        S_WCTL: if (mem_ack) st <= dma_en ? S_WSTA : S_IDLE;
        S_WSTA: if (mem_ack) begin
          ev_bd_done  <= ctl[16];
          ev_pkt_done <= ctl[17] && stop;
          if (!dma_en || stop) st <= S_IDLE;
          else begin
            ptr <= nxt;
            st  <= S_RCTL;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r1_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));
  a_r2_err_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ev_err |-> $past(mem_ack && !mem_we) && !busy);
  a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_len) && $stable(cmd_lanes) && $stable(cmd_rx));
  a_r4_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_len <= LW'(MAXLEN));
  a_r5_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  a_r8_bd_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bd_done |-> $past(mem_ack && mem_we));
  a_r9_pkt_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pkt_done |-> !busy);

endmodule

// File: tb/spi_desc_dma_test.sv
module spi_desc_dma_test;
  localparam int AW = 32;
  localparam int LW = 9;

  logic clk = 0, rst_n = 0;
  logic dma_en = 0, poll_en = 0, go = 0;
  logic [AW-1:0] base_addr = '0;
  logic busy, mem_req, mem_we, mem_ack;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic cmd_valid, cmd_ready, cmd_rx, cmd_lsb_first, cmd_ddr, cmd_cs_release, cmd_last, cmd_status_poll;
  logic [LW-1:0] cmd_len;
  logic [1:0] cmd_lanes, cmd_dev;
  logic tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0] tx_data, rx_data;
  logic ev_bd_done, ev_pkt_done, ev_err;

  always #5 clk = ~clk;

  spi_desc_dma #(.AW(AW)) uut (.*);

  logic [31:0] mem [0:1023];
  logic [18:0] cmd_log [0:255];
  logic [7:0]  tx_log [0:4095];
  int cmd_n = 0, tx_n = 0, rx_k = 0, bd_n = 0, pkt_n = 0, err_n = 0, acc_n = 0, cyc = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [7:0] rxb(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction
  assign rx_data = rxb(rx_k);

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ack <= 0; cmd_ready <= 0; tx_ready <= 0; rx_valid <= 0;
    end else begin
      mem_ack <= mem_req && !mem_ack;
      if (mem_req && !mem_ack) begin
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[11:2]];
        acc_n <= acc_n + 1;
      end
      cmd_ready <= ($urandom % 3) != 0;
      tx_ready  <= ($urandom % 3) != 0;
      if (!rx_valid || rx_ready) rx_valid <= ($urandom % 4) != 0;
      if (rx_valid && rx_ready) rx_k <= rx_k + 1;
      if (cmd_valid && cmd_ready) begin
        cmd_log[cmd_n & 255] <= {cmd_len, cmd_rx, cmd_lanes, cmd_lsb_first, cmd_ddr,
                                 cmd_dev, cmd_cs_release, cmd_last, cmd_status_poll};
        cmd_n <= cmd_n + 1;
      end
      if (tx_valid && tx_ready) begin
        tx_log[tx_n & 4095] <= tx_data;
        tx_n <= tx_n + 1;
      end
      if (ev_bd_done)  bd_n  <= bd_n + 1;
      if (ev_pkt_done) pkt_n <= pkt_n + 1;
      if (ev_err)      err_n <= err_n + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_len(logic [31:0] c);
    return (c[8:0] > 256) ? 256 : int'(c[8:0]);
  endfunction

  function automatic logic [18:0] exp_cmd(logic [31:0] c);
    logic [1:0] ln;
    ln = c[23] ? 2'd2 : (c[22] ? 2'd1 : 2'd0);
    return {9'(exp_len(c)), c[20], ln, c[25], c[21], c[29:28], c[30], c[18], c[27]};
  endfunction

  function automatic logic [7:0] memb(int ba);
    return mem[(ba >> 2) & 1023][8 * (ba % 4) +: 8];
  endfunction

  logic [31:0] d_addr [0:7], d_ctl [0:7], d_buf [0:7], d_nxt [0:7];
  int nd;

  task automatic pulse_go();
    @(negedge clk) go = 1;
    @(negedge clk) go = 0;
  endtask

  task automatic wait_idle(input int lim);
    int k = 0;
    while (busy && k < lim) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic put_spare();
    mem[32'h3C0 >> 2] = 32'h8009_0004;
    mem[(32'h3C0 >> 2) + 1] = 0;
    mem[(32'h3C0 >> 2) + 2] = 32'h0F00;
    mem[(32'h3C0 >> 2) + 3] = 0;
  endtask

  task automatic run_chain(input string tag, input bit probe);
    int c0, t0, b0, p0, e0, r0, tb, rb, bad, ln, ebd, etx;
    for (int i = 0; i < nd; i++) begin
      mem[d_addr[i] >> 2] = d_ctl[i];
      mem[(d_addr[i] >> 2) + 1] = 32'hFFFF_FFFF;
      mem[(d_addr[i] >> 2) + 2] = d_buf[i];
      mem[(d_addr[i] >> 2) + 3] = d_nxt[i];
      for (int w = 0; w < 64; w++)
        mem[(d_buf[i] >> 2) + w] = d_ctl[i][20] ? 32'hA5A5_A5A5 : $urandom;
    end
    put_spare();
    c0 = cmd_n; t0 = tx_n; b0 = bd_n; p0 = pkt_n; e0 = err_n; r0 = rx_k;
    base_addr = d_addr[0];
    pulse_go();
    if (probe) begin
      repeat (6) @(negedge clk);
      base_addr = 32'h3C0;
      pulse_go();
    end
    wait_idle(20000);
    repeat (2) @(negedge clk);
    chk(!busy, {tag, " R1 engine idle after chain"}, busy, 0);
    chk(cmd_n - c0 == nd, {tag, " R1 commands issued"}, cmd_n - c0, nd);
    tb = 0; rb = 0; ebd = 0; etx = 0;
    for (int i = 0; i < nd; i++) begin
      ln = exp_len(d_ctl[i]);
      ebd += d_ctl[i][16];
      chk(cmd_log[(c0 + i) & 255] == exp_cmd(d_ctl[i]), {tag, " R4 command fields"},
          cmd_log[(c0 + i) & 255], exp_cmd(d_ctl[i]));
      bad = 0;
      if (d_ctl[i][20]) begin
        for (int j = 0; j < ln; j++)
          if (memb(d_buf[i] + j) != rxb(r0 + rb + j)) bad++;
        for (int j = ln; j < ((ln + 3) / 4) * 4; j++)
          if (memb(d_buf[i] + j) != 8'h00) bad++;
        rb += ln;
        chk(bad == 0, {tag, " R6 receive packing"}, bad, 0);
      end else begin
        for (int j = 0; j < ln; j++)
          if (tx_log[(t0 + tb + j) & 4095] != memb(d_buf[i] + j)) bad++;
        tb += ln;
        etx += ln;
        chk(bad == 0, {tag, " R5 transmit bytes"}, bad, 0);
      end
      chk(mem[d_addr[i] >> 2] == (d_ctl[i] & 32'h7FFF_FFFF), {tag, " R7 control write-back"},
          mem[d_addr[i] >> 2], d_ctl[i] & 32'h7FFF_FFFF);
      chk(mem[(d_addr[i] >> 2) + 1] == ln, {tag, " R7 status count"}, mem[(d_addr[i] >> 2) + 1], ln);
    end
    chk(tx_n - t0 == etx, {tag, " R5 total transmit bytes"}, tx_n - t0, etx);
    chk(bd_n - b0 == ebd, {tag, " R8 descriptor events"}, bd_n - b0, ebd);
    chk(pkt_n - p0 == d_ctl[nd - 1][17], {tag, " R9 packet event"}, pkt_n - p0, d_ctl[nd - 1][17]);
    chk(err_n == e0, {tag, " R2 no error event"}, err_n - e0, 0);
  endtask

  task automatic rand_chain();
    nd = 1 + ($urandom % 4);
    for (int i = 0; i < nd; i++) begin
      d_addr[i] = 32'h40 + i * 32'h20;
      d_buf[i]  = 32'h400 + i * 32'h100;
      d_ctl[i]  = 32'h8000_0000 | ($urandom & 32'h7AF7_0000) | ($urandom % 41);
      if (i < nd - 1) d_nxt[i] = d_addr[i] + 32'h20;
      else if ($urandom % 2) begin
        d_ctl[i][19] = 1; d_nxt[i] = 32'h3C0;
      end else d_nxt[i] = 0;
    end
  endtask

  initial begin
    int c0, e0, b0, p0, a0;
    void'($urandom(32'd2024));
    for (int i = 0; i < 1024; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req && !cmd_valid && !tx_valid && !rx_ready, "R1 reset idle",
        {busy, mem_req, cmd_valid, tx_valid, rx_ready}, 0);
    chk(!ev_bd_done && !ev_pkt_done && !ev_err, "R1 reset events low",
        {ev_bd_done, ev_pkt_done, ev_err}, 0);

    // R11 start while disabled
    a0 = acc_n;
    put_spare();
    base_addr = 32'h3C0;
    pulse_go();
    repeat (5) @(negedge clk);
    chk(!busy && acc_n == a0, "R11 go ignored while disabled", acc_n - a0, 0);
    dma_en = 1;

    // directed: single transmit, restart probe (R11)
    nd = 1; d_addr[0] = 32'h40; d_buf[0] = 32'h400; d_nxt[0] = 32'h3C0;
    d_ctl[0] = 32'h800B_0005;
    run_chain("single-tx R11", 1);

    // directed: lane priority and link following
    nd = 2;
    d_addr[0] = 32'h40; d_buf[0] = 32'h400; d_nxt[0] = 32'h60;
    d_ctl[0] = 32'hE0D0_0007;
    d_addr[1] = 32'h60; d_buf[1] = 32'h500; d_nxt[1] = 0;
    d_ctl[1] = 32'h8202_0003;
    run_chain("lanes R4", 0);

    // directed: length limit
    nd = 1; d_addr[0] = 32'h40; d_buf[0] = 32'h400; d_nxt[0] = 0;
    d_ctl[0] = 32'h8009_012C;
    run_chain("clamp R4", 0);

    // directed: zero length receive
    nd = 1; d_addr[0] = 32'h40; d_buf[0] = 32'h400; d_nxt[0] = 32'h3C0;
    d_ctl[0] = 32'h801E_0000;
    run_chain("zero-len R6", 0);

    // R2 unowned, polling off
    mem[32'h80 >> 2] = 32'h0009_0004; mem[(32'h80 >> 2) + 1] = 32'h1234;
    mem[(32'h80 >> 2) + 2] = 32'h400; mem[(32'h80 >> 2) + 3] = 0;
    c0 = cmd_n; e0 = err_n;
    base_addr = 32'h80;
    pulse_go();
    wait_idle(200);
    repeat (2) @(negedge clk);
    chk(err_n - e0 == 1, "R2 error event", err_n - e0, 1);
    chk(!busy && cmd_n == c0, "R2 halted without command", cmd_n - c0, 0);
    chk(mem[32'h80 >> 2] == 32'h0009_0004 && mem[(32'h80 >> 2) + 1] == 32'h1234,
        "R2 no write-back", mem[(32'h80 >> 2) + 1], 32'h1234);

    // R3 polling
    poll_en = 1;
    c0 = cmd_n; e0 = err_n; b0 = bd_n;
    pulse_go();
    repeat (40) @(negedge clk);
    chk(busy && cmd_n == c0 && err_n == e0, "R3 waits on unowned descriptor", cmd_n - c0, 0);
    mem[32'h80 >> 2] = 32'h8009_0004;
    wait_idle(2000);
    repeat (2) @(negedge clk);
    chk(cmd_n - c0 == 1 && bd_n - b0 == 1, "R3 proceeds once owned", cmd_n - c0, 1);
    chk(mem[32'h80 >> 2] == 32'h0009_0004, "R3 write-back after poll", mem[32'h80 >> 2], 32'h0009_0004);
    poll_en = 0;

    // R10 abort
    mem[32'h80 >> 2] = 32'h800B_00C8; mem[(32'h80 >> 2) + 3] = 0;
    b0 = bd_n; p0 = pkt_n;
    pulse_go();
    repeat (40) @(negedge clk);
    dma_en = 0;
    wait_idle(40);
    repeat (2) @(negedge clk);
    chk(!busy, "R10 idle after abort", busy, 0);
    chk(bd_n == b0 && pkt_n == p0, "R10 no completion on abort", bd_n - b0 + pkt_n - p0, 0);
    chk(mem[32'h80 >> 2] == 32'h800B_00C8, "R10 no write-back on abort", mem[32'h80 >> 2], 32'h800B_00C8);
    dma_en = 1;

    for (int it = 0; it < 8; it++) begin
      rand_chain();
      run_chain("random R1", 0);
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule